// File: doc/BRIEF.md
# Bit-Band Alias Access Bridge

This block is a memory-mapped slave placed on a 32 MB alias window. Each 32-bit word in the window stands for a single bit of a backing memory region. The backing region starts at a base address given as a parameter. A read through the window fetches the backing unit that holds the bit. That unit is a byte, a halfword or a word, chosen by the access size. The read returns the bit as the value 0 or 1. A write performs a locked read-modify-write on the backing memory. It sets or clears that one bit and leaves every other bit of the unit as it was.

On the upstream side there is a single-outstanding request port (valid/ready) and a one-cycle response strobe. On the downstream side the bridge acts as a master onto the backing memory. That port has a request/grant handshake, a read-data or write-acknowledge strobe, an error flag and a lock line. The lock line holds off other masters for the whole read-modify-write. Backing data uses little-endian lanes, so bit n of a halfword or word sits in byte lane n/8 of the 32-bit data bus.

Top module: `bitband_bridge`

## Requirements
- R1: The downstream address of every access is BASE OR (up_offset >> 5), then aligned for the access size.
- R2: With up_size = 0 (byte), the address is not aligned, the bit index inside the byte is up_offset[4:2], and the byte enable is 1 << (address[1:0]).
- R3: With up_size = 1 (halfword), address bit 0 is forced to zero, the bit index is up_offset[5:2], and the byte enables are 4'b0011 (address[1] = 0) or 4'b1100 (address[1] = 1).
- R4: With up_size = 2 (word), and with the reserved code 3 treated the same way, address bits [1:0] are forced to zero, the bit index is up_offset[6:2], and all four byte enables are set.
- R5: A read response carries the selected backing bit in up_rdata[0], and up_rdata[31:1] are zero. A write response returns all-zero data.
- R6: A write reads the unit, then writes it back with the selected bit equal to up_wdata[0] and all other bits of the unit unchanged.
- R7: For a write, dn_lock is high from the first cycle of the read request until the write acknowledge. For a read, dn_lock stays low.
- R8: A read access issues no downstream write.
- R9: up_ready is low from the cycle after an accepted request until the response has been given, so only one access is outstanding.
- R10: A downstream error on the read phase ends the access with no write-back. Any downstream error is reported as up_err = 1 with the response.
- R11: While dn_req waits for dn_gnt, dn_req, dn_we and dn_addr stay stable.
- R12: During and after reset, up_ready is high, and dn_req, dn_lock and up_rsp_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Bridge can accept a request |
| up_write | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| up_offset | input | WIN_W | Byte offset inside the alias window |
| up_wdata | input | 32 | Write data; only bit 0 is used |
| up_rsp_valid | output | 1 | One-cycle response strobe |
| up_rdata | output | 32 | Read result (bit 0) |
| up_err | output | 1 | Response carries a downstream error |
| dn_req | output | 1 | Downstream request |
| dn_gnt | input | 1 | Downstream grant |
| dn_we | output | 1 | Downstream write enable |
| dn_lock | output | 1 | Holds the backing memory for the read-modify-write |
| dn_addr | output | ADDR_W | Backing byte address, aligned to the unit |
| dn_be | output | 4 | Byte enables of the unit |
| dn_wdata | output | 32 | Merged write-back data |
| dn_rvalid | input | 1 | Read data valid or write acknowledge |
| dn_rdata | input | 32 | Backing read data |
| dn_err | input | 1 | Error flag with dn_rvalid |

## Verification
On every cycle the assertions check these properties: the response bits above bit 0 are zero, the request and its address are held until grant, any write is issued under lock, an error strobe is followed by the response with no further request, and the bridge drops ready after it accepts a request. Only the bench scenarios can show that the correct backing bit is read or changed for each size and alignment, and that the byte enables cover the right lanes. The same applies to read accesses never writing, an aborted write leaving memory intact, and correct results while the grant stalls.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned LANES   = BUS_W / 8;
  localparam int unsigned BIDX_W  = $clog2(BUS_W);
  // each alias word (4 bytes) selects one of 8 bits of a backing byte
  localparam int unsigned ALIAS_SHIFT = 2 + 3;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_RESP
  } ctl_state_e;
endpackage

// File: rtl/bb_addr_map.sv
module bb_addr_map
  import bb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WIN_W  = 25,
  parameter logic [ADDR_W-1:0] BASE = 32'h2000_0000
) (
  input  logic [WIN_W-1:0]  off,
  input  acc_size_e         size,
  output logic [ADDR_W-1:0] addr,
  output logic [LANES-1:0]  be,
  output logic [BIDX_W-1:0] bus_bit
);
  localparam int unsigned SPAN_W = WIN_W - ALIAS_SHIFT;

  logic [SPAN_W-1:0] span;
  logic [ADDR_W-1:0] raw;
  logic              unused_lsb;

  assign span       = off[WIN_W-1:ALIAS_SHIFT];
  assign raw        = BASE | ADDR_W'(span);
  assign unused_lsb = ^off[1:0];

  always_comb begin
    case (size)
      SZ_BYTE: begin
        addr    = raw;
        be      = 4'b0001 << raw[1:0];
        bus_bit = {raw[1:0], off[4:2]};
      end
      SZ_HALF: begin
        addr    = {raw[ADDR_W-1:1], 1'b0};
        be      = raw[1] ? 4'b1100 : 4'b0011;
        bus_bit = {raw[1], off[5:2]};
      end
      default: begin
        addr    = {raw[ADDR_W-1:2], 2'b00};
        be      = 4'b1111;
        bus_bit = off[6:2];
      end
    endcase
  end
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
  import bb_pkg::*;
(
  input  logic [BUS_W-1:0]  rd_word,
  input  logic [BIDX_W-1:0] bus_bit,
  input  logic              set_val,
  output logic              bit_val,
  output logic [BUS_W-1:0]  wr_word
);
  assign bit_val = rd_word[bus_bit];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_in;
    logic [7:0] lane_mask;
    logic [7:0] lane_set;
    assign lane_in   = rd_word[g*8 +: 8];
    assign lane_mask = 8'h01 << bus_bit[2:0];
    assign lane_set  = {7'b0, set_val} << bus_bit[2:0];
    assign wr_word[g*8 +: 8] = (bus_bit[BIDX_W-1:3] == 2'(g))
                             ? ((lane_in & ~lane_mask) | lane_set)
                             : lane_in;
  end
endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
  import bb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic up_valid,
  input  logic up_write,
  input  logic dn_gnt,
  input  logic dn_rvalid,
  input  logic dn_err,
  output logic up_ready,
  output logic accept,
  output logic dn_req,
  output logic dn_we,
  output logic dn_lock,
  output logic rsp_valid,
  output logic rd_done,
  output logic fault,
  output logic is_wr
);
  ctl_state_e state_q, state_d;
  logic       wr_q;

  assign up_ready  = (state_q == ST_IDLE);
  assign accept    = up_ready && up_valid;
  assign dn_req    = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign dn_we     = (state_q == ST_WR_REQ);
  assign dn_lock   = wr_q && (state_q inside {ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_WR_WAIT});
  assign rsp_valid = (state_q == ST_RESP);
  assign rd_done   = (state_q == ST_RD_WAIT) && dn_rvalid && !dn_err;
  assign fault     = ((state_q == ST_RD_WAIT) || (state_q == ST_WR_WAIT)) && dn_rvalid && dn_err;
  assign is_wr     = wr_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (up_valid)  state_d = ST_RD_REQ;
      ST_RD_REQ:  if (dn_gnt)    state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (dn_rvalid) state_d = (dn_err || !wr_q) ? ST_RESP : ST_WR_REQ;
      ST_WR_REQ:  if (dn_gnt)    state_d = ST_WR_WAIT;
      ST_WR_WAIT: if (dn_rvalid) state_d = ST_RESP;
      ST_RESP:                   state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) wr_q <= up_write;
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !up_ready); // R9
  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && dn_we) |-> dn_lock); // R7
  AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_rvalid && dn_err) |=> (!dn_req && rsp_valid)); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && !dn_gnt) |=> (dn_req && $stable(dn_we))); // R11
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WIN_W  = 25,
  parameter logic [ADDR_W-1:0] BASE = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic              up_write,
  input  logic [1:0]        up_size,
  input  logic [WIN_W-1:0]  up_offset,
  input  logic [31:0]       up_wdata,
  output logic              up_rsp_valid,
  output logic [31:0]       up_rdata,
  output logic              up_err,
  output logic              dn_req,
  input  logic              dn_gnt,
  output logic              dn_we,
  output logic              dn_lock,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [3:0]        dn_be,
  output logic [31:0]       dn_wdata,
  input  logic              dn_rvalid,
  input  logic [31:0]       dn_rdata,
  input  logic              dn_err
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic accept, rd_done, fault, is_wr;
  logic [WIN_W-1:0]  off_q;
  acc_size_e         size_q;
  logic              wbit_q;
  logic [BUS_W-1:0]  wr_data_q, merged;
  logic              rbit_q, bit_val, err_q;
  logic [BIDX_W-1:0] bus_bit;
  logic              unused_wdata;

  assign unused_wdata = ^up_wdata[31:1];

  bb_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .up_valid  (up_valid),
    .up_write  (up_write),
    .dn_gnt    (dn_gnt),
    .dn_rvalid (dn_rvalid),
    .dn_err    (dn_err),
    .up_ready  (up_ready),
    .accept    (accept),
    .dn_req    (dn_req),
    .dn_we     (dn_we),
    .dn_lock   (dn_lock),
    .rsp_valid (up_rsp_valid),
    .rd_done   (rd_done),
    .fault     (fault),
    .is_wr     (is_wr)
  );

  bb_addr_map #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .BASE(BASE)) u_map (
    .off     (off_q),
    .size    (size_q),
    .addr    (dn_addr),
    .be      (dn_be),
    .bus_bit (bus_bit)
  );

  bb_bit_merge u_merge (
    .rd_word (dn_rdata),
    .bus_bit (bus_bit),
    .set_val (wbit_q),
    .bit_val (bit_val),
    .wr_word (merged)
  );

  // request capture
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      off_q  <= '0;
      size_q <= SZ_BYTE;
      wbit_q <= 1'b0;
    end else if (accept) begin
      off_q  <= up_offset;
      size_q <= acc_size_e'(up_size);
      wbit_q <= up_wdata[0];
    end
  end

  // read-phase capture and error flag
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_data_q <= '0;
      rbit_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (rd_done) begin
        wr_data_q <= merged;
        rbit_q    <= bit_val;
      end
      if (accept)     err_q <= 1'b0;
      else if (fault) err_q <= 1'b1;
    end
  end

  assign dn_wdata = wr_data_q;
  assign up_err   = up_rsp_valid && err_q;
  assign up_rdata = {31'b0, up_rsp_valid && !err_q && !is_wr && rbit_q};

  AST_RDATA_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    up_rsp_valid |-> (up_rdata[31:1] == 31'b0)); // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dn_req && !dn_gnt) |=> $stable(dn_addr)); // R11
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dn_req && size_q inside {SZ_WORD, SZ_RSVD}) |-> (dn_addr[1:0] == 2'b00)); // R4
  AST_HALF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dn_req && size_q == SZ_HALF) |-> !dn_addr[0]); // R3
  AST_IN_BACKING: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dn_req |-> ((dn_addr & BASE) == BASE)); // R1
endmodule

// File: tb/tb_bitband_bridge.sv
module tb_bitband_bridge;
  localparam logic [31:0] BASE = 32'h2000_0000;
  localparam int NVEC = 15;
  // {we[28], size[27:26], wbit[25], offset[24:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    {3'b0, 1'b0, 2'd0, 1'b0, 25'h0000000},
    {3'b0, 1'b0, 2'd0, 1'b0, 25'h000001C},
    {3'b0, 1'b1, 2'd0, 1'b1, 25'h0000024},
    {3'b0, 1'b0, 2'd0, 1'b0, 25'h0000024},
    {3'b0, 1'b0, 2'd1, 1'b0, 25'h0000040},
    {3'b0, 1'b1, 2'd1, 1'b0, 25'h000007C},
    {3'b0, 1'b0, 2'd1, 1'b0, 25'h000007C},
    {3'b0, 1'b1, 2'd2, 1'b1, 25'h0000FFC},
    {3'b0, 1'b0, 2'd2, 1'b0, 25'h0000FFC},
    {3'b0, 1'b1, 2'd2, 1'b0, 25'h0000F80},
    {3'b0, 1'b0, 2'd0, 1'b0, 25'h0000F80},
    {3'b0, 1'b1, 2'd0, 1'b0, 25'h0001FE0},
    {3'b0, 1'b0, 2'd3, 1'b0, 25'h0001FE0},
    {3'b0, 1'b1, 2'd1, 1'b1, 25'h0000A28},
    {3'b0, 1'b0, 2'd0, 1'b0, 25'h0000A28}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        up_valid = 1'b0, up_write = 1'b0;
  logic [1:0]  up_size = 2'd0;
  logic [24:0] up_offset = '0;
  logic [31:0] up_wdata = '0;
  logic        up_ready, up_rsp_valid, up_err;
  logic [31:0] up_rdata;
  logic        dn_req, dn_we, dn_lock, dn_gnt;
  logic [31:0] dn_addr, dn_wdata;
  logic [3:0]  dn_be;
  logic        dn_rvalid, dn_err;
  logic [31:0] dn_rdata;

  bitband_bridge #(.ADDR_W(32), .WIN_W(25), .BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n),
    .up_valid(up_valid), .up_ready(up_ready), .up_write(up_write),
    .up_size(up_size), .up_offset(up_offset), .up_wdata(up_wdata),
    .up_rsp_valid(up_rsp_valid), .up_rdata(up_rdata), .up_err(up_err),
    .dn_req(dn_req), .dn_gnt(dn_gnt), .dn_we(dn_we), .dn_lock(dn_lock),
    .dn_addr(dn_addr), .dn_be(dn_be), .dn_wdata(dn_wdata),
    .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata), .dn_err(dn_err)
  );

  // backing memory model: 64 words, grant optionally stalled on odd cycles
  logic [31:0] mem [64];
  logic [31:0] ref_mem [64];
  logic [31:0] rd_addr;
  logic [3:0]  last_be;
  int          wr_count;
  int          err_req = 0, err_done;
  int          cyc = 0;
  logic        stall_en = 1'b0;
  int          n_vec = 0, n_bad = 0;
  logic        done = 1'b0;

  assign dn_gnt = dn_req && !(stall_en && cyc[0]);

  function automatic logic [31:0] pattern(input int i);
    return (i * 32'h0103_0507) ^ 32'h5A3C_96E1;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= pattern(i);
      dn_rvalid <= 1'b0; dn_err <= 1'b0; dn_rdata <= '0;
      wr_count <= 0; err_done <= 0; rd_addr <= '0; last_be <= '0;
    end else begin
      dn_rvalid <= 1'b0;
      dn_err    <= 1'b0;
      if (dn_req && dn_gnt) begin
        dn_rvalid <= 1'b1;
        if (err_req != err_done) begin
          dn_err   <= 1'b1;
          err_done <= err_done + 1;
        end else if (dn_we) begin
          for (int l = 0; l < 4; l++)
            if (dn_be[l]) mem[dn_addr[7:2]][l*8 +: 8] <= dn_wdata[l*8 +: 8];
          wr_count <= wr_count + 1;
          last_be  <= dn_be;
        end else begin
          dn_rdata <= mem[dn_addr[7:2]];
          rd_addr  <= dn_addr;
        end
      end
    end
  end

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 100000", cyc);
      report();
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec = n_vec + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [1:0] sz, input logic wb, input logic [24:0] off,
                        output logic [31:0] rd, output logic e, output int rdy_bad, output int lock_bad);
    rdy_bad = 0; lock_bad = 0; rd = '0; e = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 50 && !up_ready; k++) @(negedge clk);
    up_valid = 1'b1; up_write = we; up_size = sz; up_offset = off; up_wdata = {31'h7FFF_FFFF ^ 31'h1234_5678, wb};
    @(negedge clk);
    up_valid = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if (up_rsp_valid) begin
        rd = up_rdata; e = up_err;
        break;
      end
      if (up_ready) rdy_bad++;
      if (dn_lock !== we) lock_bad++;
      @(negedge clk);
    end
  endtask

  // expected mapping from the requirements
  function automatic void expect_map(input logic [24:0] off, input logic [1:0] sz,
                                     output int au, output int bb, output logic [3:0] be);
    int ba;
    int idx;
    ba = int'(off >> 5);
    case (sz)
      2'd0: begin au = ba;        idx = int'(off[4:2]); be = 4'b0001 << (au % 4); end
      2'd1: begin au = ba & ~1;   idx = int'(off[5:2]); be = ((au % 4) >= 2) ? 4'b1100 : 4'b0011; end
      default: begin au = ba & ~3; idx = int'(off[6:2]); be = 4'b1111; end
    endcase
    bb = (au % 4) * 8 + idx;
  endfunction

  function automatic string size_tag(input logic [1:0] sz);
    return (sz == 2'd0) ? "R2" : (sz == 2'd1) ? "R3" : "R4";
  endfunction

  task automatic run_vec(input logic we, input logic [1:0] sz, input logic wb, input logic [24:0] off);
    int au, bb, wc0, rb, lb;
    logic [3:0] be;
    logic [31:0] rd;
    logic e;
    expect_map(off, sz, au, bb, be);
    wc0 = wr_count;
    access(we, sz, wb, off, rd, e, rb, lb);
    check(rd_addr == BASE + 32'(au), {"R1 ", size_tag(sz), " address"}, rd_addr, BASE + 32'(au));
    check(e == 1'b0, "R10 no error expected", 32'(e), 32'd0);
    check(rb == 0, "R9 ready low while busy", 32'(rb), 32'd0);
    check(lb == 0, "R7 lock window", 32'(lb), 32'd0);
    if (we) begin
      ref_mem[au/4][bb] = wb;
      @(negedge clk);
      check(mem[au/4] == ref_mem[au/4], {"R6 ", size_tag(sz), " merged word"}, mem[au/4], ref_mem[au/4]);
      check(last_be == be, {"R6 ", size_tag(sz), " byte enables"}, 32'(last_be), 32'(be));
      check(rd == 32'd0, "R5 write response data", rd, 32'd0);
    end else begin
      check(rd == {31'b0, ref_mem[au/4][bb]}, {"R5 ", size_tag(sz), " read bit"}, rd, {31'b0, ref_mem[au/4][bb]});
      check(wr_count == wc0, "R8 read issues no write", 32'(wr_count), 32'(wc0));
    end
  endtask

  initial begin
    logic [31:0] rd;
    logic e;
    int rb, lb, wc0, au, bb;
    logic [3:0] be;
    for (int i = 0; i < 64; i++) ref_mem[i] = pattern(i);

    // R12: reset state
    repeat (3) @(negedge clk);
    check(up_ready && !dn_req && !dn_lock && !up_rsp_valid, "R12 state in reset",
          {28'b0, up_ready, dn_req, dn_lock, up_rsp_valid}, 32'h8);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(up_ready && !dn_req && !dn_lock && !up_rsp_valid, "R12 state after reset",
          {28'b0, up_ready, dn_req, dn_lock, up_rsp_valid}, 32'h8);

    // table walk
    for (int i = 0; i < NVEC; i++)
      run_vec(VEC[i][28], VEC[i][27:26], VEC[i][25], VEC[i][24:0]);

    // R10: error on a read
    err_req = err_req + 1;
    wc0 = wr_count;
    access(1'b0, 2'd2, 1'b0, 25'h0000100, rd, e, rb, lb);
    check(e == 1'b1, "R10 read error flagged", 32'(e), 32'd1);
    check(rd == 32'd0, "R10 read error data", rd, 32'd0);

    // R10: error on the read phase of a write aborts the write-back
    expect_map(25'h0000FFC, 2'd2, au, bb, be);
    err_req = err_req + 1;
    access(1'b1, 2'd2, ~ref_mem[au/4][bb], 25'h0000FFC, rd, e, rb, lb);
    @(negedge clk);
    check(e == 1'b1, "R10 write error flagged", 32'(e), 32'd1);
    check(wr_count == wc0, "R10 no write-back after error", 32'(wr_count), 32'(wc0));
    check(mem[au/4] == ref_mem[au/4], "R10 memory unchanged", mem[au/4], ref_mem[au/4]);
    run_vec(1'b0, 2'd2, 1'b0, 25'h0000FFC);

    // R11: stalled grants
    stall_en = 1'b1;
    run_vec(1'b1, 2'd0, 1'b1, 25'h0000128);
    run_vec(1'b0, 2'd1, 1'b0, 25'h0000128);
    run_vec(1'b1, 2'd1, 1'b0, 25'h00001E4);
    run_vec(1'b0, 2'd2, 1'b0, 25'h00001E4);
    stall_en = 1'b0;

    done = 1'b1;
    report();
    $finish;
  end
endmodule